// File: doc/BRIEF.md
# Dual-Loop Phase Detector with Lock Qualification

This block sits in the digital core of a dual synthesizer. It runs on the reference oscillator clock and compares two single-cycle pulse streams for each of two loops: the divided reference `fr` and the divided feedback `fp`. Loop 0 is the low band and loop 1 the high band. For each loop it holds a phase-frequency detector state and turns it into a three-state charge-pump command: drive high, drive low, or release. The polarity bit of each loop selects which lead gives which level. The analog pump and the filter sit outside the block.

The phase error of each comparison is counted in oscillator cycles. A loop is declared locked only after several comparisons in a row fall inside a narrow window. The lock is lost as soon as a running error reaches a wider window, without waiting for the late edge. Errors between the two windows restart the run of good comparisons but leave the lock alone.

A loop in power save releases its pump, clears its detector and counts as locked for the shared pin. After reset or power save, the first comparison is measured but neither drives the pump nor counts toward lock. A single output pin shows either the combined lock or one of the four divider pulse streams, chosen by three select inputs.

Top module: `pfd_lock_mux`

## Requirements
- R1: After reset both pump commands are released (`cp_oe` = 0), and with loop 0 active and loop 1 saved the pin in lock mode reads 0.
- R2: While a loop's interval is open, `cp_oe` is 1. When `fr` led, `cp_lvl` equals the loop's `pol` bit. When `fp` led, `cp_lvl` is the inverse of `pol`.
- R3: An `fr` and an `fp` pulse in the same cycle on an idle loop give no pump drive, and they count as a comparison with error 0.
- R4: An interval that opens with a pulse in cycle c and closes with the other pulse in cycle c+k drives the pump for exactly k cycles, from the edge that ends cycle c. Its error is k.
- R5: A loop becomes locked on the edge that ends its GOOD_N-th consecutive comparison with error at most LOCK_WIN. GOOD_N-1 such comparisons are not enough.
- R6: A comparison with error above LOCK_WIN and below UNLOCK_WIN resets the good-comparison run but does not clear an existing lock.
- R7: A locked loop unlocks on the edge that ends the cycle in which its open interval reaches UNLOCK_WIN cycles. This happens even if the closing pulse has not yet come.
- R8: With `pwr_on` low, a loop never drives its pump. Its detector, lock and run are cleared, and it counts as locked in the combined status.
- R9: The first comparison after reset or after leaving power save drives no pump cycles and is not counted toward lock.
- R10: With `lds` = 0 the pin is 1 exactly when every loop is locked or in power save.
- R11: With `lds` = 1 the pin follows an input directly. `t1` picks the loop (0 low band, 1 high band) and `t2` picks the signal (0 `fr`, 1 `fp`), so {t1,t2} = 00 gives low `fr`, 10 high `fr`, 01 low `fp` and 11 high `fp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fr_in | input | 2 | Divided reference pulse, one bit per loop |
| fp_in | input | 2 | Divided feedback pulse, one bit per loop |
| pol | input | 2 | Pump polarity per loop |
| pwr_on | input | 2 | 1 = loop running, 0 = power save |
| lds | input | 1 | Pin source: 0 lock status, 1 monitored pulse |
| t1 | input | 1 | Monitor loop select |
| t2 | input | 1 | Monitor signal select |
| cp_oe | output | 2 | Pump drive enable per loop (0 = high impedance) |
| cp_lvl | output | 2 | Pump drive level per loop, 0 while released |
| mon_out | output | 1 | Shared lock / monitor pin |

## Verification
The bench builds the block with LOCK_WIN = 2, UNLOCK_WIN = 5 and GOOD_N = 3. These values leave a neutral band of errors 3 and 4, so the hysteresis case in R6 can be hit. They also let a single 7-cycle lag show the unlock landing two cycles before the interval closes. Three good comparisons keep lock acquisition short enough that hundreds of random pulse pairs, with mixed polarity, power-save toggles and select codes, repeatedly cross lock and unlock.

// File: rtl/pfd_lock_mux.sv
module pfd_lock_mux #(
  parameter int LOCK_WIN   = 2,
  parameter int UNLOCK_WIN = 4,
  parameter int GOOD_N     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fr_in,
  input  logic [1:0] fp_in,
  input  logic [1:0] pol,
  input  logic [1:0] pwr_on,
  input  logic       lds,
  input  logic       t1,
  input  logic       t2,
  output logic [1:0] cp_oe,
  output logic [1:0] cp_lvl,
  output logic       mon_out
);
  localparam int RUN_W  = $clog2(UNLOCK_WIN + 2);
  localparam int GOOD_W = $clog2(GOOD_N + 1);

  logic [1:0] lock_q;
  logic [1:0] act_q;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_loop
      logic              up_q, dn_q, skip_q, lk_q;
      logic [RUN_W-1:0]  run_q;
      logic [GOOD_W-1:0] good_q;
      logic              act, cmp, too_big, in_win, up_n, dn_n;
      logic [RUN_W-1:0]  err;

      assign act     = up_q | dn_q;
      assign cmp     = (up_q & fp_in[g]) | (dn_q & fr_in[g]) | (~act & fr_in[g] & fp_in[g]);
      assign err     = act ? run_q + 1'b1 : '0;
      assign too_big = act & (err >= RUN_W'(UNLOCK_WIN));
      assign in_win  = err <= RUN_W'(LOCK_WIN);
      assign up_n    = (up_q | fr_in[g]) & ~(dn_q | fp_in[g]);
      assign dn_n    = (dn_q | fp_in[g]) & ~(up_q | fr_in[g]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          up_q <= 1'b0; dn_q <= 1'b0; run_q <= '0;
          good_q <= '0; lk_q <= 1'b0; skip_q <= 1'b1;
        end else if (!pwr_on[g]) begin
          up_q <= 1'b0; dn_q <= 1'b0; run_q <= '0;
          good_q <= '0; lk_q <= 1'b0; skip_q <= 1'b1;
        end else begin
          up_q <= up_n;
          dn_q <= dn_n;
          if (act && !cmp)
            run_q <= (run_q == RUN_W'(UNLOCK_WIN)) ? run_q : run_q + 1'b1;
          else
            run_q <= '0;
          if (cmp) skip_q <= 1'b0;
          if (too_big) begin
            lk_q   <= 1'b0;
            good_q <= '0;
          end else if (cmp && !skip_q) begin
            if (in_win) begin
              if (good_q >= GOOD_W'(GOOD_N - 1)) begin
                lk_q   <= 1'b1;
                good_q <= GOOD_W'(GOOD_N);
              end else begin
                good_q <= good_q + 1'b1;
              end
            end else begin
              good_q <= '0;
            end
          end
        end
      end

      assign cp_oe[g]  = pwr_on[g] & act & ~skip_q;
      assign cp_lvl[g] = cp_oe[g] & (up_q == pol[g]);
      assign lock_q[g] = lk_q;
      assign act_q[g]  = act;
    end
  endgenerate

  logic lock_all, mon_sel;
  assign lock_all = &(lock_q | ~pwr_on);
  assign mon_sel  = t2 ? fp_in[t1] : fr_in[t1];
  assign mon_out  = lds ? mon_sel : lock_all;
endmodule

// File: rtl/pfd_lock_mux_chk.sv
module pfd_lock_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] fr_in,
  input logic [1:0] fp_in,
  input logic [1:0] pol,
  input logic [1:0] pwr_on,
  input logic       lds,
  input logic       t1,
  input logic       t2,
  input logic [1:0] cp_oe,
  input logic [1:0] cp_lvl,
  input logic       mon_out,
  input logic [1:0] lock_q,
  input logic [1:0] act_q
);
  genvar i;
  generate
    for (i = 0; i < 2; i++) begin : g_chk
      a_r2_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_oe[i] && $past(cp_oe[i]) && $stable(pol[i])) |-> $stable(cp_lvl[i]));
      a_r3_coincident_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on[i] && !act_q[i] && fr_in[i] && fp_in[i]) |=> !act_q[i]);
      a_r5_lock_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q[i]) |-> $past(fr_in[i] | fp_in[i]));
      a_r7_unlock_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q[i]) |-> $past(act_q[i] | ~pwr_on[i]));
      a_r8_save_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on[i] |=> !act_q[i]);
      a_r9_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on[i]) |-> !cp_oe[i]);
    end
  endgenerate

  a_r11_fr_route: assert property (@(posedge clk) disable iff (!rst_n)
    (lds && !t2) |-> (mon_out == (t1 ? fr_in[1] : fr_in[0])));
endmodule

bind pfd_lock_mux pfd_lock_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fr_in(fr_in), .fp_in(fp_in), .pol(pol),
  .pwr_on(pwr_on), .lds(lds), .t1(t1), .t2(t2), .cp_oe(cp_oe),
  .cp_lvl(cp_lvl), .mon_out(mon_out), .lock_q(lock_q), .act_q(act_q)
);

// File: tb/test_pfd_lock_mux.sv
module test_pfd_lock_mux;
  localparam int LW = 2, UW = 5, GN = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fr_in = '0, fp_in = '0, pol = 2'b11, pwr_on = 2'b01;
  logic lds = 1'b0, t1 = 1'b0, t2 = 1'b0;
  logic [1:0] cp_oe, cp_lvl;
  logic mon_out;

  pfd_lock_mux #(.LOCK_WIN(LW), .UNLOCK_WIN(UW), .GOOD_N(GN)) i_pfd_lock_mux (
    .clk(clk), .rst_n(rst_n), .fr_in(fr_in), .fp_in(fp_in), .pol(pol),
    .pwr_on(pwr_on), .lds(lds), .t1(t1), .t2(t2), .cp_oe(cp_oe),
    .cp_lvl(cp_lvl), .mon_out(mon_out));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  int lead[2], run[2], good[2];
  bit lk[2], skip[2];
  int cur_lp = 0, oe_cnt = 0, lvl_cnt = 0;
  bit done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_oe(int l);
    return pwr_on[l] && lead[l] != 0 && !skip[l];
  endfunction

  function automatic bit exp_lvl(int l);
    return exp_oe(l) && ((lead[l] == 1) == pol[l]);
  endfunction

  function automatic bit exp_mon();
    if (lds) return t2 ? fp_in[t1] : fr_in[t1];
    return (lk[0] || !pwr_on[0]) && (lk[1] || !pwr_on[1]);
  endfunction

  task automatic model_reset();
    for (int l = 0; l < 2; l++) begin
      lead[l] = 0; run[l] = 0; good[l] = 0; lk[l] = 1'b0; skip[l] = 1'b1;
    end
  endtask

  task automatic model_update();
    for (int l = 0; l < 2; l++) begin
      bit f, p, cmp, big;
      int err, nlead;
      f = fr_in[l]; p = fp_in[l];
      if (!pwr_on[l]) begin
        lead[l] = 0; run[l] = 0; good[l] = 0; lk[l] = 1'b0; skip[l] = 1'b1;
        continue;
      end
      cmp = (lead[l] == 1 && p) || (lead[l] == 2 && f) || (lead[l] == 0 && f && p);
      err = (lead[l] != 0) ? run[l] + 1 : 0;
      big = (lead[l] != 0) && (err >= UW);
      if (big) begin
        lk[l] = 1'b0; good[l] = 0;
      end else if (cmp && !skip[l]) begin
        if (err <= LW) begin
          good[l]++;
          if (good[l] >= GN) begin good[l] = GN; lk[l] = 1'b1; end
        end else good[l] = 0;
      end
      if (cmp) skip[l] = 1'b0;
      if (lead[l] == 0) nlead = (f && !p) ? 1 : ((p && !f) ? 2 : 0);
      else if (cmp) nlead = 0;
      else nlead = lead[l];
      run[l] = (lead[l] != 0 && !cmp) ? ((run[l] >= UW) ? UW : run[l] + 1) : 0;
      lead[l] = nlead;
    end
  endtask

  task automatic step(logic [1:0] fv, logic [1:0] pv);
    @(negedge clk);
    fr_in = fv; fp_in = pv;
    #1;
    for (int l = 0; l < 2; l++) begin
      chk("R2 cp_oe", cp_oe[l], exp_oe(l));
      chk("R2 cp_lvl", cp_lvl[l], exp_lvl(l));
    end
    chk(lds ? "R11 mon_out" : "R10 mon_out", mon_out, exp_mon());
    if (cp_oe[cur_lp]) oe_cnt++;
    if (cp_lvl[cur_lp]) lvl_cnt++;
    model_update();
  endtask

  task automatic pair(int lp, bit fr_first, int k);
    cur_lp = lp; oe_cnt = 0; lvl_cnt = 0;
    for (int c = 0; c <= k; c++) begin
      logic [1:0] fv, pv;
      fv = '0; pv = '0;
      if (c == 0) begin
        if (fr_first || k == 0) fv[lp] = 1'b1;
        if (!fr_first || k == 0) pv[lp] = 1'b1;
      end else if (c == k) begin
        if (fr_first) pv[lp] = 1'b1; else fv[lp] = 1'b1;
      end
      step(fv, pv);
    end
    for (int c = 0; c < 3; c++) step('0, '0);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    #12 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 cp_oe reset", cp_oe, 0);
    chk("R1 mon reset", mon_out, 0);

    pair(0, 1'b1, 1);
    chk("R9 first compare suppressed", oe_cnt, 0);
    pair(0, 1'b1, 2);
    chk("R4 drive width", oe_cnt, 2);
    chk("R2 fr lead pol1 high", lvl_cnt, 2);
    pair(0, 1'b1, 1);
    chk("R5 not locked after two", mon_out, 0);
    pair(0, 1'b1, 0);
    chk("R3 coincident no drive", oe_cnt, 0);
    chk("R5 locked after three", mon_out, 1);
    pair(0, 1'b0, 3);
    chk("R2 fp lead pol1 low", lvl_cnt, 0);
    chk("R4 fp lead width", oe_cnt, 3);
    chk("R6 neutral keeps lock", mon_out, 1);
    pair(0, 1'b1, 1);
    pair(0, 1'b1, 1);
    chk("R6 still locked", mon_out, 1);

    cur_lp = 0;
    step(2'b01, 2'b00);
    for (int j = 1; j <= 6; j++) begin
      step('0, '0);
      if (j == 5) chk("R7 lock held before limit", mon_out, 1);
      if (j == 6) begin
        chk("R7 unlocked before close", mon_out, 0);
        chk("R7 interval still open", cp_oe[0], 1);
      end
    end
    step(2'b00, 2'b01);
    for (int c = 0; c < 3; c++) step('0, '0);

    pol = 2'b10;
    pair(0, 1'b1, 2);
    chk("R2 fr lead pol0 low", lvl_cnt, 0);
    chk("R2 pol0 width", oe_cnt, 2);

    pwr_on = 2'b00;
    pair(0, 1'b1, 1);
    chk("R8 saved no drive", oe_cnt, 0);
    chk("R8 both saved read locked", mon_out, 1);
    pwr_on = 2'b10;
    step('0, '0);
    chk("R10 active unlocked loop", mon_out, 0);

    pwr_on = 2'b11;
    pair(0, 1'b1, 1);
    chk("R9 wake compare suppressed", oe_cnt, 0);
    pair(0, 1'b1, 1);
    chk("R9 next compare drives", oe_cnt, 1);

    lds = 1'b1;
    for (int code = 0; code < 4; code++) begin
      int e;
      t1 = code[1]; t2 = code[0];
      step(2'b10, 2'b01);
      e = t2 ? (t1 ? 0 : 1) : (t1 ? 1 : 0);
      chk("R11 select code", mon_out, e);
    end
    step('0, '0);

    void'($urandom(32'h5eed));
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 15);
      pwr_on = (r == 0) ? 2'($urandom_range(0, 3)) : 2'b11;
      pol = 2'($urandom_range(0, 3));
      lds = ($urandom_range(0, 3) == 0);
      t1 = 1'($urandom_range(0, 1));
      t2 = 1'($urandom_range(0, 1));
      pair($urandom_range(0, 1), 1'($urandom_range(0, 1)), $urandom_range(0, 7));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule